// File: doc/BRIEF.md
# Memory-Indirect Add Multicycle Processor Core

This block is a small multicycle processor. It holds one shared word memory, a program counter, an instruction register, a memory data register, operand latches, an ALU result register and a register file. Its control state machine runs every instruction through the same seven states. The only instruction it executes is a memory-indirect add. The instruction forms a byte address from a register plus a sign-extended 16-bit offset and reads memory there. It uses the returned word as a second address, reads memory again, adds the value of its target register to that second word, and writes the sum back into the same target register.

Memory is loaded through a word-indexed write port while the core is held in reset. The outputs show the current state, the PC, the active memory address and read strobe, the ALU result register, the memory data register, and the register-file write.

Instruction layout: source register in bits [25:21], target register in bits [20:16], signed offset in bits [15:0]. Bits [31:26] are not decoded.

Top module: `mcia_top`

## Requirements
- R1: A synchronous reset puts the state machine in fetch (state code 0), clears the PC, the ALU result register, the memory data register and every register-file entry to 0, and keeps the register-file write strobe low.
- R2: Out of reset the state codes run 0 (fetch), 1 (decode), 2 (execute1), 3 (execute2), 4 (execute3), 5 (execute4), 6 (writeback). After code 6 the machine always returns to 0.
- R3: In fetch the memory address is the PC and the instruction register loads that word. The PC becomes PC+4 at the end of fetch and holds its value in every other state.
- R4: At the end of decode the ALU result register holds the updated PC plus the sign-extended offset shifted left by 2. This value is visible during execute1.
- R5: At the end of execute1 the ALU result register holds register[source] + sign-extended offset. During execute2 this value is the memory address.
- R6: At the end of execute2 the memory data register loads the memory word at the ALU result address. This value is visible during execute3.
- R7: In execute3 the memory address is the memory data register. At the end of execute3 the memory data register loads the word at that address.
- R8: The register-file write strobe is high only in writeback. In writeback the destination is the target register and the write data is the old target value plus the second loaded word, taken modulo 2^32.
- R9: Offsets with bit 15 set are negative. For example, offset 0xFFF8 subtracts 8.
- R10: Memory is word-indexed by byte-address bits [MEM_AW+1:2]. The two low bits and all bits above the index are ignored, so addresses wrap modulo the memory size.
- R11: The memory read strobe is high in fetch, execute2 and execute3, and low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory load write enable |
| ld_idx | input | MEM_AW | Word index for a memory load |
| ld_data | input | 32 | Word written by a memory load |
| state_o | output | 3 | Current control state code |
| pc_o | output | 32 | Program counter |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 32 | Byte address presented to memory |
| mdr_o | output | 32 | Memory data register |
| alu_out_o | output | 32 | ALU result register |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |

## Verification
Each state's result is registered at the rising edge that ends that state, so it shows at the outputs during the next state. The decode target appears in execute1. The first effective address appears on the memory address in execute2. The first load appears in the memory data register in execute3, and the second load appears there in execute4. The writeback data and index are combinational from registers during writeback. The bench drives inputs and samples outputs only at falling edges. It walks a reference model one state per cycle, so every comparison is made in the state in which that value must already be present.

// File: rtl/mcia_pkg.sv
package mcia_pkg;
  parameter int XLEN   = 32;
  parameter int REG_AW = 5;
  parameter int IMM_W  = 16;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EX1    = 3'd2,
    ST_EX2    = 3'd3,
    ST_EX3    = 3'd4,
    ST_EX4    = 3'd5,
    ST_WB     = 3'd6
  } state_e;

  // Mux select encodings
  localparam logic [1:0] ADR_PC  = 2'd0, ADR_ALU = 2'd1, ADR_MDR = 2'd2;
  localparam logic [1:0] OPA_PC  = 2'd0, OPA_A   = 2'd1, OPA_MDR = 2'd2;
  localparam logic [1:0] OPB_B   = 2'd0, OPB_FOUR = 2'd1, OPB_IMM = 2'd2, OPB_IMM4 = 2'd3;
  localparam logic [1:0] DST_RT  = 2'd0, DST_RD  = 2'd1, DST_RS  = 2'd2;

  typedef struct packed {
    logic [1:0] addr_sel;
    logic [1:0] a_sel;
    logic [1:0] b_sel;
    logic       mem_rd;
    logic       ir_we;
    logic       pc_we;
    logic       ab_we;
    logic       aluout_we;
    logic       mdr_we;
    logic [1:0] dst_sel;
    logic       wd_sel;
    logic       rf_we;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] add_x(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    return x + y;
  endfunction

  function automatic logic [REG_AW-1:0] fld_rs(input logic [XLEN-1:0] ir);
    return ir[25:21];
  endfunction

  function automatic logic [REG_AW-1:0] fld_rt(input logic [XLEN-1:0] ir);
    return ir[20:16];
  endfunction

  function automatic logic [REG_AW-1:0] fld_rd(input logic [XLEN-1:0] ir);
    return ir[15:11];
  endfunction

  function automatic logic [IMM_W-1:0] fld_imm(input logic [XLEN-1:0] ir);
    return ir[IMM_W-1:0];
  endfunction
endpackage

// File: rtl/mcia_ctrl.sv
module mcia_ctrl import mcia_pkg::*; (
  input  logic   clk,
  input  logic   rst,
  output state_e state,
  output ctrl_t  ctl
);
  state_e nxt;

  always_comb begin
    if (state == ST_WB) nxt = ST_FETCH;
    else                nxt = state_e'(state + 3'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_FETCH: begin
        ctl.addr_sel = ADR_PC;
        ctl.a_sel    = OPA_PC;
        ctl.b_sel    = OPB_FOUR;
        ctl.mem_rd   = 1'b1;
        ctl.ir_we    = 1'b1;
        ctl.pc_we    = 1'b1;
      end
      ST_DECODE: begin
        ctl.a_sel     = OPA_PC;
        ctl.b_sel     = OPB_IMM4;
        ctl.ab_we     = 1'b1;
        ctl.aluout_we = 1'b1;
      end
      ST_EX1: begin
        ctl.a_sel     = OPA_A;
        ctl.b_sel     = OPB_IMM;
        ctl.aluout_we = 1'b1;
      end
      ST_EX2: begin
        ctl.addr_sel = ADR_ALU;
        ctl.mem_rd   = 1'b1;
        ctl.mdr_we   = 1'b1;
      end
      ST_EX3: begin
        ctl.addr_sel = ADR_MDR;
        ctl.mem_rd   = 1'b1;
        ctl.mdr_we   = 1'b1;
      end
      ST_EX4: begin
        ctl.a_sel     = OPA_MDR;
        ctl.b_sel     = OPB_B;
        ctl.aluout_we = 1'b1;
      end
      ST_WB: begin
        ctl.dst_sel = DST_RT;
        ctl.wd_sel  = 1'b0;
        ctl.rf_we   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcia_alu.sv
module mcia_alu import mcia_pkg::*; (
  input  logic [1:0]      a_sel,
  input  logic [1:0]      b_sel,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] a_reg,
  input  logic [XLEN-1:0] mdr,
  input  logic [XLEN-1:0] b_reg,
  input  logic [XLEN-1:0] imm_ext,
  output logic [XLEN-1:0] y
);
  logic [XLEN-1:0] opa, opb;

  always_comb begin
    case (a_sel)
      OPA_A:   opa = a_reg;
      OPA_MDR: opa = mdr;
      default: opa = pc;
    endcase
  end

  always_comb begin
    case (b_sel)
      OPB_FOUR: opb = XLEN'(4);
      OPB_IMM:  opb = imm_ext;
      OPB_IMM4: opb = {imm_ext[XLEN-3:0], 2'b00};
      default:  opb = b_reg;
    endcase
  end

  assign y = add_x(opa, opb);
endmodule

// File: rtl/mcia_regfile.sv
module mcia_regfile import mcia_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ra1,
  input  logic [REG_AW-1:0] ra2,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [XLEN-1:0]   wd
);
  localparam int NREG = 1 << REG_AW;
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/mcia_mem.sv
module mcia_mem import mcia_pkg::*; #(
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_idx,
  input  logic [XLEN-1:0] ld_data,
  input  logic [AW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [XLEN-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) words[ld_idx] <= ld_data;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/mcia_top.sv
module mcia_top import mcia_pkg::*; #(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [MEM_AW-1:0] ld_idx,
  input  logic [XLEN-1:0]   ld_data,
  output logic [2:0]        state_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              mem_rd_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mdr_o,
  output logic [XLEN-1:0]   alu_out_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o
);
  state_e          st;
  ctrl_t           ctl;
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
  logic [XLEN-1:0] mem_rdata, alu_y, imm_ext, addr_mux, rf_rd1, rf_rd2, wd_mux;
  logic [REG_AW-1:0] dst_mux;
  logic [MEM_AW-1:0] word_idx;

  // Named internal events
  logic pc_step, ir_load, mdr_load, alu_load, opnd_load;
  assign pc_step   = ctl.pc_we;
  assign ir_load   = ctl.ir_we;
  assign mdr_load  = ctl.mdr_we;
  assign alu_load  = ctl.aluout_we;
  assign opnd_load = ctl.ab_we;

  mcia_ctrl u_ctrl (.clk(clk), .rst(rst), .state(st), .ctl(ctl));

  assign imm_ext = sext_imm(fld_imm(ir_q));

  always_comb begin
    case (ctl.addr_sel)
      ADR_ALU: addr_mux = aluout_q;
      ADR_MDR: addr_mux = mdr_q;
      default: addr_mux = pc_q;
    endcase
  end
  assign word_idx = addr_mux[MEM_AW+1:2];

  mcia_mem #(.AW(MEM_AW)) u_mem (
    .clk(clk), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(word_idx), .rd_data(mem_rdata)
  );

  mcia_alu u_alu (
    .a_sel(ctl.a_sel), .b_sel(ctl.b_sel), .pc(pc_q), .a_reg(a_q),
    .mdr(mdr_q), .b_reg(b_q), .imm_ext(imm_ext), .y(alu_y)
  );

  always_comb begin
    case (ctl.dst_sel)
      DST_RD:  dst_mux = fld_rd(ir_q);
      DST_RS:  dst_mux = fld_rs(ir_q);
      default: dst_mux = fld_rt(ir_q);
    endcase
  end
  assign wd_mux = ctl.wd_sel ? mdr_q : aluout_q;

  mcia_regfile u_rf (
    .clk(clk), .rst(rst), .ra1(fld_rs(ir_q)), .ra2(fld_rt(ir_q)),
    .rd1(rf_rd1), .rd2(rf_rd2), .we(ctl.rf_we), .wa(dst_mux), .wd(wd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (pc_step)   pc_q     <= alu_y;
      if (ir_load)   ir_q     <= mem_rdata;
      if (opnd_load) begin
        a_q <= rf_rd1;
        b_q <= rf_rd2;
      end
      if (alu_load)  aluout_q <= alu_y;
      if (mdr_load)  mdr_q    <= mem_rdata;
    end
  end

  assign state_o    = st;
  assign pc_o       = pc_q;
  assign mem_rd_o   = ctl.mem_rd;
  assign mem_addr_o = addr_mux;
  assign mdr_o      = mdr_q;
  assign alu_out_o  = aluout_q;
  assign rf_we_o    = ctl.rf_we;
  assign rf_waddr_o = dst_mux;
  assign rf_wdata_o = wd_mux;
endmodule

// File: rtl/mcia_chk.sv
module mcia_chk import mcia_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        state_o,
  input logic [XLEN-1:0]   pc_o,
  input logic              mem_rd_o,
  input logic [XLEN-1:0]   mdr_o,
  input logic [XLEN-1:0]   alu_out_o,
  input logic              rf_we_o
);
  AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd6 |=> state_o == 3'd0); // R2

  AST_STATE_STEP: assert property (@(posedge clk) disable iff (rst)
    state_o != 3'd6 |=> state_o == 3'($past(state_o) + 3'd1)); // R2

  AST_PC_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
    pc_o != $past(pc_o) |-> $past(state_o) == 3'd0); // R3

  AST_ALUOUT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    alu_out_o != $past(alu_out_o) |->
      ($past(state_o) == 3'd1 || $past(state_o) == 3'd2 || $past(state_o) == 3'd5)); // R4

  AST_MDR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mdr_o != $past(mdr_o) |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd4)); // R7

  AST_RFWE_WB: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> state_o == 3'd6); // R8

  AST_MEMRD_STATES: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> (state_o == 3'd0 || state_o == 3'd3 || state_o == 3'd4)); // R11
endmodule

bind mcia_top mcia_chk u_chk (
  .clk(clk), .rst(rst), .state_o(state_o), .pc_o(pc_o), .mem_rd_o(mem_rd_o),
  .mdr_o(mdr_o), .alu_out_o(alu_out_o), .rf_we_o(rf_we_o)
);

// File: tb/sim_mcia_top.sv
`timescale 1ns/1ps
module sim_mcia_top;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NINS  = 60;
  localparam int LIMIT = 200000;

  logic clk = 1'b0, rst = 1'b1, ld_en = 1'b0;
  logic [AW-1:0] ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [2:0]  state_o;
  logic [31:0] pc_o, mem_addr_o, mdr_o, alu_out_o, rf_wdata_o;
  logic        mem_rd_o, rf_we_o;
  logic [4:0]  rf_waddr_o;

  always #5 clk = ~clk;

  mcia_top #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .state_o(state_o), .pc_o(pc_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mdr_o(mdr_o), .alu_out_o(alu_out_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] mem_m [DEPTH];
  logic [31:0] rf_m  [32];
  logic [31:0] pc_m;

  function automatic logic [31:0] sx16(input logic [15:0] v);
    logic [31:0] r;
    r = {16'h0000, v};
    if (v[15]) r = r - 32'h0001_0000;
    return r;
  endfunction

  function automatic int widx(input logic [31:0] byte_addr);
    return int'((byte_addr >> 2) % DEPTH);
  endfunction

  function automatic logic [31:0] mk_ins(input int rs, input int rt, input logic [15:0] off);
    return {6'h2A, 5'(rs), 5'(rt), off};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ins, ea, d1, d2;
    int rs, rt;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = $urandom();
    for (int i = 0; i < 32; i++) rf_m[i] = '0;
    // Directed corner instructions, then random ones
    mem_m[0] = mk_ins(0, 1, 16'h0104);
    mem_m[1] = mk_ins(1, 2, 16'hFFF8);   // negative offset (R9)
    mem_m[2] = mk_ins(3, 3, 16'h0007);   // low bits dropped, rs==rt (R10)
    mem_m[3] = mk_ins(2, 4, 16'h7FFC);
    mem_m[4] = mk_ins(0, 5, 16'h8000);   // most negative offset (R9)
    for (int i = 5; i < NINS; i++)
      mem_m[i] = mk_ins(int'($urandom_range(31)), int'($urandom_range(31)), 16'($urandom()));
    mem_m[65] = 32'hFFFF_FFFC;            // second address wraps to top word (R10)

    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      ld_en = 1'b1; ld_idx = AW'(i); ld_data = mem_m[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    chk("R1 state", 32'(state_o), 32'd0);
    chk("R1 pc", pc_o, 32'd0);
    chk("R1 aluout", alu_out_o, 32'd0);
    chk("R1 mdr", mdr_o, 32'd0);
    chk("R1 rf_we", 32'(rf_we_o), 32'd0);
    rst = 1'b0;
    pc_m = '0;

    for (int n = 0; n < NINS; n++) begin
      // fetch
      chk("R2 fetch state", 32'(state_o), 32'd0);
      chk("R3 fetch addr", mem_addr_o, pc_m);
      chk("R11 fetch rd", 32'(mem_rd_o), 32'd1);
      ins = mem_m[widx(pc_m)];
      rs = int'(ins[25:21]); rt = int'(ins[20:16]);
      step();
      // decode
      pc_m = pc_m + 32'd4;
      chk("R2 decode state", 32'(state_o), 32'd1);
      chk("R3 pc+4", pc_o, pc_m);
      chk("R11 decode no rd", 32'(mem_rd_o), 32'd0);
      chk("R8 decode no we", 32'(rf_we_o), 32'd0);
      step();
      // execute1
      chk("R2 ex1 state", 32'(state_o), 32'd2);
      chk("R4 branch target", alu_out_o, pc_m + (sx16(ins[15:0]) << 2));
      chk("R3 pc hold ex1", pc_o, pc_m);
      step();
      // execute2
      ea = rf_m[rs] + sx16(ins[15:0]);
      chk("R2 ex2 state", 32'(state_o), 32'd3);
      chk("R5 R9 eff addr", mem_addr_o, ea);
      chk("R11 ex2 rd", 32'(mem_rd_o), 32'd1);
      step();
      // execute3
      d1 = mem_m[widx(ea)];
      chk("R2 ex3 state", 32'(state_o), 32'd4);
      chk("R6 R10 first load", mdr_o, d1);
      chk("R7 indirect addr", mem_addr_o, d1);
      chk("R11 ex3 rd", 32'(mem_rd_o), 32'd1);
      step();
      // execute4
      d2 = mem_m[widx(d1)];
      chk("R2 ex4 state", 32'(state_o), 32'd5);
      chk("R7 R10 second load", mdr_o, d2);
      chk("R8 ex4 no we", 32'(rf_we_o), 32'd0);
      step();
      // writeback
      chk("R2 wb state", 32'(state_o), 32'd6);
      chk("R8 wb we", 32'(rf_we_o), 32'd1);
      chk("R8 wb dest", 32'(rf_waddr_o), 32'(rt));
      chk("R8 wb data", rf_wdata_o, rf_m[rt] + d2);
      chk("R11 wb no rd", 32'(mem_rd_o), 32'd0);
      rf_m[rt] = rf_m[rt] + d2;
      step();
    end
    chk("R2 return to fetch", 32'(state_o), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule